// File: doc/BRIEF.md
# Byte Write Strobe Qualifier

This block sits between the raw active-low control pins of a byte-programmable memory and its page-load logic. It oversamples chip-enable, write-enable, output-enable, the address and data buses and a digital supply-good flag with a fast system clock. It turns a valid write strobe into a single-cycle byte-write event that carries a captured address and data byte.

Either enable can serve as the strobe. The window opens when the second of the two enables goes low, and the address is taken at that moment. The window closes when the first of them goes high again, and the data byte is taken at that moment. A strobe that is too short, that overlaps output-enable low, or that arrives while the supply is not good or still settling produces no event.

A three-state machine drives the qualification. The states are as follows:

- ST_DRAIN is the reset state. It waits until both enables are high and then goes to ST_IDLE.
- ST_IDLE watches for both enables low.
  - If writes are allowed, it goes to ST_ARMED (arm).
  - If writes are blocked, it goes to ST_DRAIN (refuse).
- ST_ARMED counts the low time.
  - If output-enable falls or the lockout reasserts, it goes to ST_DRAIN (abort).
  - If one enable rises, it goes to ST_DRAIN (release). A release fires the event only when the window lasted at least the minimum width.

Top module: `wsq_top`

## Requirements
- R1: With chip-enable held low, a write-enable low pulse of at least MIN_PULSE clock cycles, with output-enable high, produces exactly one event.
- R2: With write-enable held low, a chip-enable low pulse of at least MIN_PULSE clock cycles, with output-enable high, produces exactly one event.
- R3: The event address is the value on the address input in the cycle the later of the two enables falls. Address changes after that cycle do not alter it.
- R4: The event data is the value on the data input in the cycle the first of the two enables rises. Data changes after that cycle do not alter it.
- R5: A window where both enables are low for fewer than MIN_PULSE cycles produces no event. A window of exactly MIN_PULSE cycles produces one.
- R6: No event results if output-enable is low when the window opens, or if it goes low at any time before the window closes.
- R7: While supply-good is low, no strobe produces an event.
- R8: After supply-good rises, strobes are ignored for PWRUP_CYCLES cycles. Each drop of supply-good restarts that delay.
- R9: `wr_valid` is high for exactly one cycle per event. `wr_addr` and `wr_data` change only in the cycle `wr_valid` is high and hold their values otherwise.
- R10: During and after reset, `wr_valid`, `wr_addr` and `wr_data` are zero until the first event.
- R11: A low pulse on one enable while the other stays high produces no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n_pin | input | 1 | Raw active-low chip-enable |
| we_n_pin | input | 1 | Raw active-low write-enable |
| oe_n_pin | input | 1 | Raw active-low output-enable |
| addr_pin | input | AW | Raw address bus |
| data_pin | input | DW | Raw data bus |
| supply_ok | input | 1 | Digital supply-good indication |
| wr_valid | output | 1 | One-cycle byte-write event |
| wr_addr | output | AW | Address captured for the event |
| wr_data | output | DW | Data captured for the event |

## Verification
Writes are strobed by write-enable under a held chip-enable, and then by chip-enable under a held write-enable, with several address and data values. This distinguishes the two strobe roles. Overlapping windows move the address after the falling edge and the data between the first and second rising edges, which shows which edge each field is taken from. Windows of MIN_PULSE-1 and MIN_PULSE cycles bracket the glitch threshold. Strobes are also tried with output-enable low or falling mid-window, with a single enable, with supply-good low, and both just after and well after supply-good rises, to separate each blocking cause from the lockout delay.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_DRAIN = 2'd2
    } wsq_state_e;

    localparam int unsigned CTRL_BITS = 3;
    localparam int unsigned CTRL_CE   = 0;
    localparam int unsigned CTRL_WE   = 1;
    localparam int unsigned CTRL_OE   = 2;

endpackage

// File: rtl/wsq_sync.sv
module wsq_sync #(
    parameter int unsigned W        = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic sync_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
            end else begin
                meta_q <= d_in[i];
                sync_q <= meta_q;
            end
        end

        assign d_out[i] = sync_q;
    end

endmodule

// File: rtl/wsq_lockout.sv
module wsq_lockout #(
    parameter int unsigned PWRUP_CYCLES = 625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pg_s,
    output logic lock_ok
);

    localparam int unsigned LW = $clog2(PWRUP_CYCLES + 1);
    localparam logic [LW-1:0] LIMIT = LW'(PWRUP_CYCLES);

    logic [LW-1:0] settle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q <= '0;
            lock_ok  <= 1'b0;
        end else if (!pg_s) begin
            settle_q <= '0;
            lock_ok  <= 1'b0;
        end else begin
            if (settle_q != LIMIT) begin
                settle_q <= settle_q + 1'b1;
            end
            lock_ok <= (settle_q == LIMIT);
        end
    end

endmodule

// File: rtl/wsq_strobe_fsm.sv
module wsq_strobe_fsm
    import wsq_pkg::*;
#(
    parameter int unsigned AW        = 15,
    parameter int unsigned DW        = 8,
    parameter int unsigned MIN_PULSE = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_s,
    input  logic          we_s,
    input  logic          oe_s,
    input  logic          lock_ok,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [$clog2(MIN_PULSE+1)-1:0] width_q
);

    localparam int unsigned CW = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] MIN_C = CW'(MIN_PULSE);

    wsq_state_e state_q, state_d;
    logic [AW-1:0] addr_hold_q;
    logic          window;
    logic          allowed;
    logic          fire;

    assign window  = !ce_s && !we_s;
    assign allowed = oe_s && lock_ok;

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (window) begin
                    state_d = allowed ? ST_ARMED : ST_DRAIN;
                end
            end
            ST_ARMED: begin
                if (!allowed) begin
                    state_d = ST_DRAIN;
                end else if (!window) begin
                    state_d = ST_DRAIN;
                    fire    = (width_q >= MIN_C);
                end
            end
            ST_DRAIN: begin
                if (ce_s && we_s) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_DRAIN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DRAIN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q     <= '0;
            addr_hold_q <= '0;
            wr_valid    <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
        end else begin
            wr_valid <= fire;
            if (state_q == ST_IDLE && window && allowed) begin
                width_q     <= CW'(1);
                addr_hold_q <= addr_s;
            end else if (state_q == ST_ARMED && window && width_q != MIN_C) begin
                width_q <= width_q + 1'b1;
            end
            if (fire) begin
                wr_addr <= addr_hold_q;
                wr_data <= data_s;
            end
        end
    end

endmodule

// File: rtl/wsq_top.sv
module wsq_top
    import wsq_pkg::*;
#(
    parameter int unsigned AW           = 15,
    parameter int unsigned DW           = 8,
    parameter int unsigned MIN_PULSE    = 2,
    parameter int unsigned PWRUP_CYCLES = 625000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n_pin,
    input  logic          we_n_pin,
    input  logic          oe_n_pin,
    input  logic [AW-1:0] addr_pin,
    input  logic [DW-1:0] data_pin,
    input  logic          supply_ok,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);

    localparam int unsigned BW = AW + DW;
    localparam int unsigned CW = $clog2(MIN_PULSE + 1);

    logic [CTRL_BITS-1:0] ctrl_raw, ctrl_s;
    logic [BW-1:0]        bus_s;
    logic                 pg_s;
    logic                 ce_s, we_s, oe_s;
    logic                 lock_ok;
    logic [CW-1:0]        width_q;

    assign ctrl_raw[CTRL_CE] = ce_n_pin;
    assign ctrl_raw[CTRL_WE] = we_n_pin;
    assign ctrl_raw[CTRL_OE] = oe_n_pin;

    wsq_sync #(.W(CTRL_BITS), .RST_VAL('1)) u_sync_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (ctrl_raw),
        .d_out(ctrl_s)
    );

    wsq_sync #(.W(BW), .RST_VAL('0)) u_sync_bus (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in ({addr_pin, data_pin}),
        .d_out(bus_s)
    );

    wsq_sync #(.W(1), .RST_VAL(1'b0)) u_sync_pg (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (supply_ok),
        .d_out(pg_s)
    );

    assign ce_s = ctrl_s[CTRL_CE];
    assign we_s = ctrl_s[CTRL_WE];
    assign oe_s = ctrl_s[CTRL_OE];

    wsq_lockout #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .pg_s   (pg_s),
        .lock_ok(lock_ok)
    );

    wsq_strobe_fsm #(.AW(AW), .DW(DW), .MIN_PULSE(MIN_PULSE)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_s    (ce_s),
        .we_s    (we_s),
        .oe_s    (oe_s),
        .lock_ok (lock_ok),
        .addr_s  (bus_s[BW-1:DW]),
        .data_s  (bus_s[DW-1:0]),
        .wr_valid(wr_valid),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .width_q (width_q)
    );

endmodule

// File: rtl/wsq_checker.sv
module wsq_checker #(
    parameter int unsigned AW        = 15,
    parameter int unsigned DW        = 8,
    parameter int unsigned MIN_PULSE = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_s,
    input logic          we_s,
    input logic          oe_s,
    input logic          lock_ok,
    input logic          wr_valid,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data
);

    localparam int unsigned RW = $clog2(MIN_PULSE + 1);
    localparam logic [RW-1:0] RMAX = RW'(MIN_PULSE);

    // independent length of the current low window, saturating
    logic [RW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!ce_s && !we_s) begin
            if (run_q != RMAX) run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    a_r9_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({wr_addr, wr_data}) |-> wr_valid);

    a_r8_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(lock_ok));

    a_r6_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(oe_s));

    a_r11_both_low_before: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ($past(!ce_s && !we_s, 2) && $past(ce_s || we_s)));

    a_r5_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ($past(run_q) >= RMAX));

endmodule

bind wsq_top wsq_checker #(.AW(AW), .DW(DW), .MIN_PULSE(MIN_PULSE)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_s    (ce_s),
    .we_s    (we_s),
    .oe_s    (oe_s),
    .lock_ok (lock_ok),
    .wr_valid(wr_valid),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
);

// File: tb/wsq_top_test.sv
module wsq_top_test;

    localparam int unsigned AW = 15;
    localparam int unsigned DW = 8;
    localparam int unsigned MINP = 3;
    localparam int unsigned PWRUP = 40;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic          pg = 1'b1;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int    n_tests = 0;
    int    n_fail = 0;
    int    cycles = 0;
    string cur_req = "R10";
    item_t exp_q[$];

    always #4 clk = ~clk;

    wsq_top #(.AW(AW), .DW(DW), .MIN_PULSE(MINP), .PWRUP_CYCLES(PWRUP)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n_pin(ce_n), .we_n_pin(we_n), .oe_n_pin(oe_n),
        .addr_pin(addr), .data_pin(data), .supply_ok(pg),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pop and compare each event
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, cur_req, "unexpected event addr", longint'(wr_addr), 0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(wr_addr == e.addr, cur_req, "event addr", longint'(wr_addr), longint'(e.addr));
                check(wr_data == e.data, cur_req, "event data", longint'(wr_data), longint'(e.data));
            end
        end
    end

    // monitor: event pulse lasts one cycle (R9)
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (rst_n && prev_valid && wr_valid)
            check(1'b0, "R9", "valid longer than one cycle", 1, 0);
        prev_valid <= wr_valid;
    end

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
        item_t e;
        e.addr = a;
        e.data = d;
        exp_q.push_back(e);
    endtask

    // use_ce=0: CE held low, WE strobes; use_ce=1: WE held low, CE strobes
    task automatic strobe(input bit use_ce, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int len, input bit expect_ev);
        if (expect_ev) push(a, d);
        @(negedge clk);
        addr = a;
        data = d;
        if (use_ce) we_n = 1'b0; else ce_n = 1'b0;
        wait_cyc(1);
        if (use_ce) ce_n = 1'b0; else we_n = 1'b0;
        wait_cyc(len);
        if (use_ce) ce_n = 1'b1; else we_n = 1'b1;
        wait_cyc(1);
        ce_n = 1'b1;
        we_n = 1'b1;
        wait_cyc(4);
    endtask

    task automatic drained(input string req);
        wait_cyc(6);
        check(exp_q.size() == 0, req, "missing events", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        // R10: reset state
        wait_cyc(3);
        check(wr_valid == 1'b0, "R10", "valid in reset", wr_valid, 0);
        check(wr_addr == '0, "R10", "addr in reset", wr_addr, 0);
        check(wr_data == '0, "R10", "data in reset", wr_data, 0);
        rst_n = 1'b1;

        // R8: strobe during the settle delay after supply good
        cur_req = "R8";
        wait_cyc(2);
        strobe(1'b0, 15'h0123, 8'h11, 4, 1'b0);
        drained("R8");
        wait_cyc(PWRUP + 10);
        check(wr_valid == 1'b0, "R10", "valid idle after reset", wr_valid, 0);

        // R1: WE as strobe
        cur_req = "R1";
        strobe(1'b0, 15'h1234, 8'hA5, 4, 1'b1);
        strobe(1'b0, 15'h7FFF, 8'h00, 6, 1'b1);
        strobe(1'b0, 15'h0000, 8'hFF, 5, 1'b1);
        drained("R1");

        // R9: fields hold between events
        check(wr_addr == 15'h0000 && wr_data == 8'hFF, "R9", "fields held", wr_data, 8'hFF);

        // R2: CE as strobe
        cur_req = "R2";
        strobe(1'b1, 15'h2A2A, 8'h5A, 4, 1'b1);
        strobe(1'b1, 15'h0040, 8'hC3, 7, 1'b1);
        drained("R2");

        // R3: address from the later falling edge
        cur_req = "R3";
        push(15'h0BEE, 8'h77);
        addr = 15'h0AAA; data = 8'h77;
        ce_n = 1'b0;
        wait_cyc(2);
        addr = 15'h0BEE;
        wait_cyc(1);
        we_n = 1'b0;
        wait_cyc(2);
        addr = 15'h0CCC;
        wait_cyc(3);
        we_n = 1'b1;
        wait_cyc(1);
        ce_n = 1'b1;
        drained("R3");

        // R4: data from the first rising edge
        cur_req = "R4";
        push(15'h0321, 8'h3C);
        addr = 15'h0321; data = 8'h3C;
        ce_n = 1'b0; we_n = 1'b0;
        wait_cyc(4);
        we_n = 1'b1;
        wait_cyc(2);
        data = 8'hC3;
        wait_cyc(2);
        ce_n = 1'b1;
        drained("R4");

        // R5: width threshold
        cur_req = "R5";
        strobe(1'b0, 15'h0101, 8'h01, MINP - 1, 1'b0);
        strobe(1'b1, 15'h0102, 8'h02, 1, 1'b0);
        drained("R5");
        strobe(1'b0, 15'h0103, 8'h03, MINP, 1'b1);
        drained("R5");

        // R6: output-enable low blocks
        cur_req = "R6";
        oe_n = 1'b0;
        strobe(1'b0, 15'h0200, 8'h20, 5, 1'b0);
        oe_n = 1'b1;
        drained("R6");
        addr = 15'h0201; data = 8'h21;
        ce_n = 1'b0; we_n = 1'b0;
        wait_cyc(2);
        oe_n = 1'b0;
        wait_cyc(3);
        we_n = 1'b1; ce_n = 1'b1;
        wait_cyc(2);
        oe_n = 1'b1;
        drained("R6");

        // R11: one enable only
        cur_req = "R11";
        @(negedge clk);
        addr = 15'h0300; data = 8'h30;
        we_n = 1'b0;
        wait_cyc(6);
        we_n = 1'b1;
        wait_cyc(2);
        ce_n = 1'b0;
        wait_cyc(6);
        ce_n = 1'b1;
        drained("R11");

        // R7: supply not good
        cur_req = "R7";
        pg = 1'b0;
        wait_cyc(4);
        strobe(1'b0, 15'h0400, 8'h40, 5, 1'b0);
        strobe(1'b1, 15'h0401, 8'h41, 5, 1'b0);
        drained("R7");

        // R8: delay restarts after supply returns
        cur_req = "R8";
        pg = 1'b1;
        wait_cyc(3);
        strobe(1'b0, 15'h0500, 8'h50, 5, 1'b0);
        drained("R8");
        wait_cyc(PWRUP);
        strobe(1'b0, 15'h0501, 8'h51, 5, 1'b1);
        drained("R8");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule